// File: doc/BRIEF.md
# LIN frame header and checksum engine

This block is the protocol layer of a LIN node. It sits beside a byte-level receiver and has its own bit-level transmit serializer. One write of a 6-bit frame identifier makes the transmitter send the whole master header with no further help. The header is a long low break, a one-bit high delimiter, the sync byte 0x55 and the protected identifier, whose two parity bits are computed in hardware. Each byte is sent in asynchronous format: a low start bit, eight data bits with the least significant bit first, and a programmable stop period.

In the response phase the transmitter adds every data byte it sends into an 8-bit sum. The carry out of each addition is folded back into the sum. A command then appends the bitwise inverse of that sum as the checksum byte. On the receive side, the block watches the raw line for a break and counts the bytes that the external receiver delivers after it. It accumulates the same sum and checks it against the received checksum byte. An auto-baud unit measures the sync byte and reports a new cycles-per-bit divisor. Schedule tables, timeouts and the choice between publishing and subscribing stay outside the block and reach it through control inputs.

Top module: `lin_engine`

## Requirements
- R1: When the block is idle, a pulse on `id_wr` starts a header. From the next clock edge `txd` is low for 13 bit periods (break), then high for exactly 1 bit period (delimiter). One bit period is `bit_div` clock cycles.
- R2: Right after the delimiter the block sends the byte 0x55, then the protected identifier. Every byte is sent as a low start bit followed by 8 data bits, least significant bit first, each bit lasting one bit period. The same format is used for bytes sent by `tx_wr` and `tx_csum`.
- R3: The protected identifier carries the identifier in bits 5..0, the value id0^id1^id2^id4 in bit 6, and the value ~(id1^id3^id4^id5) in bit 7.
- R4: After every byte, `txd` stays high for a stop period set by `stop_sel`: 0 gives 1 bit period, 1 gives 1.5 bit periods, and 2 or 3 give 2 bit periods. When a header is in progress, the identifier's start bit follows the sync byte's stop period directly.
- R5: The transmit sum is cleared when a header starts. In enhanced mode (`enhanced`=1) the identifier byte is added; in legacy mode it is not. Every byte sent through `tx_wr` is added. Each addition folds its carry back in. A pulse on `tx_csum` sends the bitwise inverse of the sum.
- R6: A detected break clears the receive sum and `csum_err`. After the break, the first received byte (sync) is not added. The second byte (identifier) is added only in enhanced mode. Later bytes are added with the carry folded back in. A byte that arrives with `rx_last`=1 is added instead to produce a result: `csum_done` pulses for one cycle and `csum_err` is set unless the result is 0xFF.
- R7: `brk_det` pulses exactly once when `rxd` has been low for 11 bit periods. A low period shorter than that gives no pulse.
- R8: After a pulse on `abd_arm`, the block counts clock cycles from the first to the fifth falling edge of `rxd`. It then loads `abd_div` with that count divided by 8 and raises `abd_done`. `abd_done` stays high until the next arm.
- R9: After reset, `txd` is high, `tx_ready` is high, and `csum_err`, `abd_done` and `brk_det` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_div | input | DIV_W | Clock cycles per bit period |
| stop_sel | input | 2 | Stop period select: 0 = 1, 1 = 1.5, 2 or 3 = 2 bit periods |
| enhanced | input | 1 | 1 = identifier included in checksum |
| id_wr | input | 1 | Start a header (accepted when idle) |
| id | input | 6 | Frame identifier |
| tx_wr | input | 1 | Send one response byte (accepted when idle) |
| tx_byte | input | 8 | Response byte |
| tx_csum | input | 1 | Send the inverted transmit sum (accepted when idle) |
| tx_ready | output | 1 | Transmitter idle |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Raw serial input |
| rx_valid | input | 1 | A byte from the external receiver is present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | The present byte is the checksum byte |
| brk_det | output | 1 | Break detected pulse |
| csum_done | output | 1 | Checksum compared pulse |
| csum_err | output | 1 | Checksum mismatch |
| abd_arm | input | 1 | Arm the auto-baud measurement |
| abd_done | output | 1 | Auto-baud result valid |
| abd_div | output | DIV_W | Measured cycles per bit |

## Verification
A wrong transmit state shows on `txd` within one bit period: a break of the wrong length, a missing delimiter, or a byte whose bits are shifted. Each of these is caught by measuring widths and sampling at mid-bit. A wrong identifier parity or a wrong checksum sum shows up as a wrong byte on the line, in the same frame. On the receive side, a byte index that is off or a sum that was not cleared flips `csum_err` on the very next checksum byte. A wrong edge count in auto-baud shows as a wrong `abd_div` as soon as `abd_done` rises.

// File: rtl/lin_engine.sv
`timescale 1ns/1ps
module lin_engine #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] bit_div,
  input  logic [1:0]       stop_sel,
  input  logic             enhanced,
  input  logic             id_wr,
  input  logic [5:0]       id,
  input  logic             tx_wr,
  input  logic [7:0]       tx_byte,
  input  logic             tx_csum,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             brk_det,
  output logic             csum_done,
  output logic             csum_err,
  input  logic             abd_arm,
  output logic             abd_done,
  output logic [DIV_W-1:0] abd_div
);
  localparam int CW = DIV_W + 4;
  localparam int AW = DIV_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_BRK, S_DEL, S_BIT, S_STOP} st_t;

  function automatic logic [7:0] add_eac(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  st_t         state;
  logic [CW-1:0] cnt, len;
  logic [3:0]  bidx;
  logic [8:0]  sh;
  logic        hdrq;
  logic [7:0]  pid_q, tx_sum;

  wire [CW-1:0] div_w = CW'(bit_div);
  wire [7:0] pid_w = {~(id[1]^id[3]^id[4]^id[5]), id[0]^id[1]^id[2]^id[4], id};

  always_comb begin
    case (state)
      S_BRK:   len = div_w * CW'(13);
      S_STOP:  len = (stop_sel == 2'd0) ? div_w :
                     (stop_sel == 2'd1) ? div_w + (div_w >> 1) : div_w << 1;
      default: len = div_w;
    endcase
  end

  assign txd      = (state == S_BRK) ? 1'b0 : (state == S_BIT) ? sh[0] : 1'b1;
  assign tx_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; bidx <= '0; sh <= '1;
      hdrq <= 1'b0; pid_q <= '0; tx_sum <= '0;
    end else if (state == S_IDLE) begin
      cnt  <= '0;
      bidx <= '0;
      if (id_wr) begin
        state <= S_BRK; pid_q <= pid_w; hdrq <= 1'b1; tx_sum <= '0;
      end else if (tx_wr) begin
        state <= S_BIT; sh <= {tx_byte, 1'b0}; tx_sum <= add_eac(tx_sum, tx_byte);
      end else if (tx_csum) begin
        state <= S_BIT; sh <= {~tx_sum, 1'b0};
      end
    end else if (cnt != len - 1'b1) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      case (state)
        S_BRK: state <= S_DEL;
        S_DEL: begin state <= S_BIT; sh <= {8'h55, 1'b0}; bidx <= '0; end
        S_BIT: begin
          sh <= sh >> 1;
          if (bidx == 4'd8) state <= S_STOP;
          else bidx <= bidx + 1'b1;
        end
        S_STOP: begin
          if (hdrq) begin
            hdrq <= 1'b0; state <= S_BIT; bidx <= '0; sh <= {pid_q, 1'b0};
            if (enhanced) tx_sum <= add_eac(tx_sum, pid_q);
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && id_wr) |=> (state == S_BRK && !txd));
  // R1
  brk_to_del_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BRK) |=> (state == S_BRK || state == S_DEL));
  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BIT) |-> (bidx <= 4'd8));

  logic [1:0]    rs;
  logic          lp;
  logic [CW-1:0] lowc;
  wire           line = rs[1];
  wire           fall = lp & ~line;
  wire [CW-1:0]  brk_len = div_w * CW'(11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs <= 2'b11; lp <= 1'b1; lowc <= '0; brk_det <= 1'b0;
    end else begin
      rs <= {rs[0], rxd};
      lp <= line;
      if (line) lowc <= '0;
      else if (lowc != brk_len) lowc <= lowc + 1'b1;
      brk_det <= !line && (lowc == brk_len - 1'b1);
    end
  end

  // R7
  brk_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> !brk_det);

  logic [1:0] rx_idx;
  logic [7:0] rx_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_idx <= '0; rx_sum <= '0; csum_done <= 1'b0; csum_err <= 1'b0;
    end else begin
      csum_done <= 1'b0;
      if (brk_det) begin
        rx_idx <= '0; rx_sum <= '0; csum_err <= 1'b0;
      end else if (rx_valid) begin
        if (rx_idx != 2'd2) rx_idx <= rx_idx + 1'b1;
        if (rx_idx == 2'd1) begin
          if (enhanced) rx_sum <= add_eac(rx_sum, rx_data);
        end else if (rx_idx == 2'd2) begin
          if (rx_last) begin
            csum_done <= 1'b1;
            csum_err  <= (add_eac(rx_sum, rx_data) != 8'hFF);
          end else begin
            rx_sum <= add_eac(rx_sum, rx_data);
          end
        end
      end
    end
  end

  // R6
  rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> (rx_sum == 8'h00 && !csum_err));

  logic          armed;
  logic [2:0]    edges;
  logic [AW-1:0] acnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; edges <= '0; acnt <= '0; abd_done <= 1'b0; abd_div <= '0;
    end else if (abd_arm) begin
      armed <= 1'b1; edges <= '0; abd_done <= 1'b0;
    end else if (armed) begin
      if (fall) edges <= edges + 1'b1;
      if (fall && edges == 3'd0) acnt <= AW'(1);
      else if (edges != 3'd0) acnt <= acnt + 1'b1;
      if (fall && edges == 3'd4) begin
        abd_div <= acnt[AW-1:3]; abd_done <= 1'b1; armed <= 1'b0;
      end
    end
  end

  // R8
  abd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abd_done) |-> !armed);
endmodule

// File: tb/lin_engine_tb.sv
`timescale 1ns/1ps
module lin_engine_tb;
  localparam int DIV = 8;

  logic clk = 0, rst_n = 0;
  logic [15:0] bit_div = DIV;
  logic [1:0] stop_sel = 0;
  logic enhanced = 0, id_wr = 0, tx_wr = 0, tx_csum = 0;
  logic [5:0] id = 0;
  logic [7:0] tx_byte = 0, rx_data = 0;
  logic rxd = 1, rx_valid = 0, rx_last = 0, abd_arm = 0;
  logic tx_ready, txd, brk_det, csum_done, csum_err, abd_done;
  logic [15:0] abd_div;
  int tests = 0, fails = 0, brk_cnt = 0, done_cnt = 0;
  bit finished = 0;

  lin_engine u_dut (.clk(clk), .rst_n(rst_n), .bit_div(bit_div), .stop_sel(stop_sel),
    .enhanced(enhanced), .id_wr(id_wr), .id(id), .tx_wr(tx_wr), .tx_byte(tx_byte),
    .tx_csum(tx_csum), .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .brk_det(brk_det), .csum_done(csum_done),
    .csum_err(csum_err), .abd_arm(abd_arm), .abd_done(abd_done), .abd_div(abd_div));

  always #5 clk = ~clk;
  always @(posedge clk) begin
    if (brk_det) brk_cnt++;
    if (csum_done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pid_of(input logic [5:0] i);
    return {~(i[1]^i[3]^i[4]^i[5]), i[0]^i[1]^i[2]^i[4], i};
  endfunction

  function automatic logic [7:0] eac(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s > 255) s = s - 255;
    return s[7:0];
  endfunction

  task automatic get_serial(output logic [7:0] b, output int stop_len, output logic st);
    repeat (DIV/2) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = txd;
    end
    repeat (DIV/2) @(negedge clk);
    stop_len = 0;
    while (txd && stop_len < 300) begin
      stop_len++;
      @(negedge clk);
    end
  endtask

  task automatic send_header(input logic [5:0] i, output int lo, output int hi,
                             output logic [7:0] syn, output int sl, output logic [7:0] pid);
    int dummy;
    logic s0, s1;
    @(negedge clk); id = i; id_wr = 1;
    @(negedge clk); id_wr = 0;
    lo = 0;
    while (!txd && lo < 300) begin lo++; @(negedge clk); end
    hi = 0;
    while (txd && hi < 300) begin hi++; @(negedge clk); end
    get_serial(syn, sl, s0);
    get_serial(pid, dummy, s1);
    chk(s0 == 0 && s1 == 0, "R2 start bits", {s0, s1}, 0);
  endtask

  task automatic send_byte(input bit csum, input logic [7:0] d, output logic [7:0] got);
    int sl;
    logic s;
    @(negedge clk);
    if (csum) tx_csum = 1; else begin tx_byte = d; tx_wr = 1; end
    @(negedge clk); tx_csum = 0; tx_wr = 0;
    get_serial(got, sl, s);
  endtask

  task automatic t_reset;
    chk(txd == 1 && tx_ready == 1, "R9 reset tx", {txd, tx_ready}, 2'b11);
    chk(!csum_err && !abd_done && !brk_det, "R9 reset flags", {csum_err, abd_done, brk_det}, 0);
  endtask

  task automatic t_header;
    int lo, hi, sl;
    logic [7:0] syn, pid;
    int exp_stop [4] = '{DIV, DIV + DIV/2, 2*DIV, 2*DIV};
    logic [5:0] ids [4] = '{6'h3C, 6'h00, 6'h2A, 6'h3F};
    for (int k = 0; k < 4; k++) begin
      stop_sel = 2'(k);
      send_header(ids[k], lo, hi, syn, sl, pid);
      chk(lo == 13*DIV, "R1 break length", lo, 13*DIV);
      chk(hi == DIV, "R1 delimiter length", hi, DIV);
      chk(syn == 8'h55, "R2 sync byte", syn, 8'h55);
      chk(pid == pid_of(ids[k]), "R3 protected id", pid, pid_of(ids[k]));
      chk(sl == exp_stop[k], "R4 stop length", sl, exp_stop[k]);
    end
    stop_sel = 0;
  endtask

  task automatic t_tx_csum(input bit enh, input logic [5:0] i);
    int lo, hi, sl;
    logic [7:0] syn, pid, got, sum;
    logic [7:0] dat [4] = '{8'h4A, 8'hF5, 8'h93, 8'hE5};
    enhanced = enh;
    send_header(i, lo, hi, syn, sl, pid);
    sum = enh ? pid_of(i) : 8'h00;
    for (int k = 0; k < 4; k++) begin
      send_byte(0, dat[k], got);
      chk(got == dat[k], "R2 response byte", got, dat[k]);
      sum = eac(sum, dat[k]);
    end
    send_byte(1, 8'h00, got);
    chk(got == ~sum, enh ? "R5 enhanced checksum" : "R5 legacy checksum", got, ~sum);
  endtask

  task automatic t_break;
    int b0;
    b0 = brk_cnt;
    @(negedge clk); rxd = 0;
    repeat (10*DIV) @(negedge clk);
    rxd = 1;
    repeat (10) @(negedge clk);
    chk(brk_cnt == b0, "R7 short low ignored", brk_cnt - b0, 0);
    rxd = 0;
    repeat (12*DIV) @(negedge clk);
    rxd = 1;
    repeat (10) @(negedge clk);
    chk(brk_cnt == b0 + 1, "R7 break once", brk_cnt - b0, 1);
  endtask

  task automatic rx_put(input logic [7:0] d, input bit last);
    @(negedge clk); rx_data = d; rx_valid = 1; rx_last = last;
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic t_rx_csum(input bit enh, input bit corrupt);
    logic [7:0] p, sum, ck;
    int d0;
    logic [7:0] dat [3] = '{8'h81, 8'hC4, 8'hFE};
    enhanced = enh;
    t_break_quiet();
    p = pid_of(6'h15);
    sum = enh ? p : 8'h00;
    rx_put(8'h55, 0);
    rx_put(p, 0);
    for (int k = 0; k < 3; k++) begin rx_put(dat[k], 0); sum = eac(sum, dat[k]); end
    ck = ~sum;
    if (corrupt) ck = ck + 8'h01;
    d0 = done_cnt;
    rx_put(ck, 1);
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R6 checksum done", done_cnt - d0, 1);
    chk(csum_err == corrupt, "R6 checksum flag", csum_err, corrupt);
  endtask

  task automatic t_break_quiet;
    @(negedge clk); rxd = 0;
    repeat (12*DIV) @(negedge clk);
    rxd = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_abd;
    logic [9:0] fr;
    fr = {1'b1, 8'h55, 1'b0};
    @(negedge clk); abd_arm = 1;
    @(negedge clk); abd_arm = 0;
    chk(!abd_done, "R8 cleared on arm", abd_done, 0);
    for (int k = 0; k < 10; k++) begin
      rxd = fr[k];
      repeat (20) @(negedge clk);
    end
    rxd = 1;
    repeat (5) @(negedge clk);
    chk(abd_done == 1, "R8 done", abd_done, 1);
    chk(abd_div == 16'd20, "R8 divisor", abd_div, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_header();
    t_tx_csum(1, 6'h10);
    t_tx_csum(0, 6'h23);
    t_break();
    t_rx_csum(0, 0);
    t_rx_csum(1, 0);
    t_rx_csum(1, 1);
    t_rx_csum(0, 1);
    t_abd();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule